// File: doc/BRIEF.md
# Character LCD Start-up Sequencer

This block brings a parallel character display out of power-up on its own, with no processor involved. It drives an 8-bit data bus and three control lines: register select, read/write and enable. After a synchronous reset it steps through a fixed script of five writes. The first four are configuration commands: 8-bit bus with two lines, then display and cursor on, then clear, then move the cursor to line 1, column 4. The fifth is a single character write, the letter 'A'.

Each write has the same shape. The byte and the register-select level are placed on the pins while enable is low. Enable is then raised for a programmable number of clocks and lowered again. The bus is held for one more clock, and a programmable wait follows before the next write. Read/write never leaves the write level.

When the wait after the character write ends, a done flag rises. The block then stays idle with enable low until the next reset. A reset at any point, including in the middle of a transfer, pulls enable low and restarts the script from its first command.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is high, enable and done are low on the clock after reset is first sampled, and they stay low.
- R2: The first four writes carry the bytes 0x38, 0x0E, 0x01, 0x84, in that order, each with register select low (0 = command).
- R3: The fifth write carries 0x41 (ASCII 'A') with register select high (1 = data).
- R4: Read/write is low (0 = write) in every cycle.
- R5: Every enable pulse stays high for exactly EN_HIGH_CYC clock cycles.
- R6: Data bus and register select hold the same value from one cycle before enable rises, through the whole pulse, until one cycle after enable falls.
- R7: Counting the first clock edge with reset low as cycle 1, the k-th enable rise (k = 0..4) is seen after cycle 2 + k·(EN_HIGH_CYC + STEP_WAIT_CYC + 3). Between a fall and the next rise, enable is low for exactly STEP_WAIT_CYC + 3 cycles. The default wait of 400000 cycles is 2 ms at 200 MHz, which covers the clear command's 1.64 ms. The default pulse of 100 cycles is 500 ns.
- R8: Done rises after cycle 5·(EN_HIGH_CYC + STEP_WAIT_CYC + 3). It stays high with enable low until reset.
- R9: A reset issued in the middle of the script restarts it, so the next write is again 0x38 with the full timing of R7.
- R10: Exactly five enable pulses occur between one reset and the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_db | output | 8 | Data bus to the display |
| lcd_rs | output | 1 | Register select: 0 command, 1 character data |
| lcd_rw | output | 1 | Read/write, always 0 (write) |
| lcd_en | output | 1 | Enable strobe |
| done | output | 1 | High once the script has finished |

## Verification
The bench builds the block with EN_HIGH_CYC = 4 and STEP_WAIT_CYC = 7. One script step is then 14 cycles and a whole run is 70 cycles, so each run is seen end to end several times, including a reset in the middle of the second write. A four-cycle pulse lets bus stability be checked over several high cycles rather than one. Every rise and fall lands on a cycle number that can be worked out from the step length. The millisecond defaults are not exercised in simulation; they only enter through the formulas in R7.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int LCD_DW     = 8;
  localparam int SCRIPT_LEN = 5;
  localparam int IDX_W      = $clog2(SCRIPT_LEN);

  // One script entry: target register and byte value
  typedef struct packed {
    logic              is_data;
    logic [LCD_DW-1:0] code;
  } lcd_xfer_t;

  typedef enum logic [2:0] {
    PH_SETUP,
    PH_ARM,
    PH_PULSE,
    PH_HOLD,
    PH_WAIT,
    PH_DONE
  } lcd_phase_e;

endpackage

// File: rtl/lcd_script_rom.sv
module lcd_script_rom
  import lcd_init_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output lcd_xfer_t        xfer,
  output logic             last
);

  always_comb begin
    case (idx)
      IDX_W'(0): xfer = '{is_data: 1'b0, code: 8'h38}; // 8-bit bus, two lines
      IDX_W'(1): xfer = '{is_data: 1'b0, code: 8'h0E}; // display on, cursor on
      IDX_W'(2): xfer = '{is_data: 1'b0, code: 8'h01}; // clear
      IDX_W'(3): xfer = '{is_data: 1'b0, code: 8'h84}; // cursor line 1, col 4
      IDX_W'(4): xfer = '{is_data: 1'b1, code: 8'h41}; // character 'A'
      default:   xfer = '{is_data: 1'b0, code: 8'h00};
    endcase
  end

  assign last = (idx == IDX_W'(SCRIPT_LEN - 1));

endmodule

// File: rtl/lcd_cycle_timer.sv
module lcd_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] term,
  output logic             at_end
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + 1'b1;
  end

  assign at_end = run && (cnt_q == term);

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  lcd_xfer_t         xfer,
  input  logic              last,
  input  logic              tmr_end,
  output logic [IDX_W-1:0]  idx,
  output logic              tmr_run,
  output logic              tmr_clr,
  output logic              sel_wait,
  output logic [LCD_DW-1:0] lcd_db,
  output logic              lcd_rs,
  output logic              lcd_en,
  output logic              done
);

  lcd_phase_e phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_SETUP;
      idx    <= '0;
      lcd_db <= '0;
      lcd_rs <= 1'b0;
      lcd_en <= 1'b0;
      done   <= 1'b0;
    end else begin
      case (phase)
        PH_SETUP: begin
          lcd_db <= xfer.code;
          lcd_rs <= xfer.is_data;
          phase  <= PH_ARM;
        end
        PH_ARM: begin
          lcd_en <= 1'b1;
          phase  <= PH_PULSE;
        end
        PH_PULSE: begin
          if (tmr_end) begin
            lcd_en <= 1'b0;
            phase  <= PH_HOLD;
          end
        end
        PH_HOLD: phase <= PH_WAIT;
        PH_WAIT: begin
          if (tmr_end) begin
            if (last) begin
              done  <= 1'b1;
              phase <= PH_DONE;
            end else begin
              idx   <= idx + 1'b1;
              phase <= PH_SETUP;
            end
          end
        end
        PH_DONE: lcd_en <= 1'b0;
        default: phase <= PH_SETUP;
      endcase
    end
  end

  assign tmr_run  = (phase == PH_PULSE) || (phase == PH_WAIT);
  assign tmr_clr  = (phase == PH_ARM) || (phase == PH_HOLD) || tmr_end;
  assign sel_wait = (phase == PH_WAIT);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int EN_HIGH_CYC   = 100,
  parameter int STEP_WAIT_CYC = 400000
) (
  input  logic              clk,
  input  logic              rst,
  output logic [LCD_DW-1:0] lcd_db,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_en,
  output logic              done
);

  localparam int MAX_CYC = (EN_HIGH_CYC > STEP_WAIT_CYC) ? EN_HIGH_CYC : STEP_WAIT_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] PULSE_TERM = CNT_W'(EN_HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_TERM  = CNT_W'(STEP_WAIT_CYC - 1);

  logic [IDX_W-1:0] idx;
  lcd_xfer_t        xfer;
  logic             last;
  logic             tmr_run, tmr_clr, tmr_end, sel_wait;
  logic [CNT_W-1:0] term;

  lcd_script_rom u_rom (
    .idx  (idx),
    .xfer (xfer),
    .last (last)
  );

  assign term = sel_wait ? WAIT_TERM : PULSE_TERM;

  lcd_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .run    (tmr_run),
    .clr    (tmr_clr),
    .term   (term),
    .at_end (tmr_end)
  );

  lcd_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .xfer     (xfer),
    .last     (last),
    .tmr_end  (tmr_end),
    .idx      (idx),
    .tmr_run  (tmr_run),
    .tmr_clr  (tmr_clr),
    .sel_wait (sel_wait),
    .lcd_db   (lcd_db),
    .lcd_rs   (lcd_rs),
    .lcd_en   (lcd_en),
    .done     (done)
  );

  assign lcd_rw = 1'b0;

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter int EN_HIGH_CYC   = 100,
  parameter int STEP_WAIT_CYC = 400000
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] lcd_db,
  input logic       lcd_rs,
  input logic       lcd_en,
  input logic       done
);

  logic [31:0] hi_cnt, lo_cnt;
  logic        en_q, seen_fall;
  logic [3:0]  n_pulses;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      en_q      <= 1'b0;
      seen_fall <= 1'b0;
      n_pulses  <= '0;
    end else begin
      hi_cnt    <= lcd_en ? hi_cnt + 32'd1 : 32'd0;
      lo_cnt    <= lcd_en ? 32'd0 : lo_cnt + 32'd1;
      en_q      <= lcd_en;
      seen_fall <= seen_fall | (en_q & ~lcd_en);
      if (lcd_en && !en_q && n_pulses != 4'hF) n_pulses <= n_pulses + 4'd1;
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> hi_cnt == EN_HIGH_CYC); // R5

  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs)); // R6

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
    $past(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs)); // R6

  AST_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |=> $stable(lcd_db) && $stable(lcd_rs)); // R6

  AST_STEP_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(lcd_en) && seen_fall) |-> lo_cnt == STEP_WAIT_CYC + 3); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !lcd_en); // R8

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R8

  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_en) |-> n_pulses < 4'd5); // R10

endmodule

bind lcd_init_seq lcd_init_seq_chk #(
  .EN_HIGH_CYC   (EN_HIGH_CYC),
  .STEP_WAIT_CYC (STEP_WAIT_CYC)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .lcd_db (lcd_db),
  .lcd_rs (lcd_rs),
  .lcd_en (lcd_en),
  .done   (done)
);

// File: tb/lcd_init_seq_test.sv
`timescale 1ns/1ps
module lcd_init_seq_test;

  localparam int EN      = 4;
  localparam int WT      = 7;
  localparam int PER     = EN + WT + 3;
  localparam int DONE_AT = 5 * PER;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] lcd_db;
  logic       lcd_rs, lcd_rw, lcd_en, done;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lcd_init_seq #(.EN_HIGH_CYC(EN), .STEP_WAIT_CYC(WT)) uut (
    .clk(clk), .rst(rst), .lcd_db(lcd_db), .lcd_rs(lcd_rs),
    .lcd_rw(lcd_rw), .lcd_en(lcd_en), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_xfer(input int k);
    case (k)
      0: return {1'b0, 8'h38};
      1: return {1'b0, 8'h0E};
      2: return {1'b0, 8'h01};
      3: return {1'b0, 8'h84};
      default: return {1'b1, 8'h41};
    endcase
  endfunction

  // Watches one full run from the cycle after reset release and checks it
  task automatic run_and_check(input string tag);
    logic [7:0] got_db[8];
    logic       got_rs[8];
    int         got_rise[8];
    int         got_width[8];
    int         n_pul = 0;
    int         rw_bad = 0, setup_bad = 0, stab_bad = 0, hold_bad = 0;
    int         early = 0, late = 0, en_done = 0;
    int         hold_s = -1;
    logic       prev_en = 1'b0;
    logic [7:0] prev_db = lcd_db;
    logic       prev_rs = lcd_rs;
    for (int i = 0; i < 8; i++) begin
      got_db[i] = '0; got_rs[i] = 1'b0; got_rise[i] = -1; got_width[i] = -1;
    end
    for (int s = 1; s <= DONE_AT + 12; s++) begin
      @(negedge clk);
      if (lcd_rw !== 1'b0) rw_bad++;
      if (lcd_en && !prev_en) begin
        if (n_pul < 8) begin
          got_db[n_pul] = lcd_db; got_rs[n_pul] = lcd_rs; got_rise[n_pul] = s;
        end
        if (lcd_db !== prev_db || lcd_rs !== prev_rs) setup_bad++;
        n_pul++;
      end
      if (lcd_en && prev_en && (lcd_db !== prev_db || lcd_rs !== prev_rs)) stab_bad++;
      if (!lcd_en && prev_en) begin
        if (n_pul >= 1 && n_pul <= 8) got_width[n_pul-1] = s - got_rise[n_pul-1];
        if (lcd_db !== prev_db || lcd_rs !== prev_rs) hold_bad++;
        hold_s = s + 1;
      end
      if (s == hold_s && (lcd_db !== prev_db || lcd_rs !== prev_rs)) hold_bad++;
      if (s < DONE_AT && done) early++;
      if (s >= DONE_AT && !done) late++;
      if (done && lcd_en) en_done++;
      prev_en = lcd_en; prev_db = lcd_db; prev_rs = lcd_rs;
    end
    chk(n_pul == 5, "R10", {tag, " pulse count"}, n_pul, 5);
    for (int k = 0; k < 5; k++) begin
      logic [8:0] e;
      e = exp_xfer(k);
      chk(got_db[k] == e[7:0], (k < 4) ? "R2" : "R3", {tag, " byte"}, got_db[k], e[7:0]);
      chk(got_rs[k] == e[8], (k < 4) ? "R2" : "R3", {tag, " reg select"}, got_rs[k], e[8]);
      chk(got_rise[k] == 2 + k * PER, "R7", {tag, " rise cycle"}, got_rise[k], 2 + k * PER);
      chk(got_width[k] == EN, "R5", {tag, " pulse width"}, got_width[k], EN);
    end
    chk(rw_bad == 0, "R4", {tag, " rw not low"}, rw_bad, 0);
    chk(setup_bad == 0, "R6", {tag, " setup"}, setup_bad, 0);
    chk(stab_bad == 0, "R6", {tag, " stable while high"}, stab_bad, 0);
    chk(hold_bad == 0, "R6", {tag, " hold after fall"}, hold_bad, 0);
    chk(early == 0, "R8", {tag, " done early"}, early, 0);
    chk(late == 0, "R8", {tag, " done late"}, late, 0);
    chk(en_done == 0, "R8", {tag, " enable after done"}, en_done, 0);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(lcd_en == 1'b0, "R1", "enable in reset", lcd_en, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    chk(lcd_rw == 1'b0, "R4", "rw in reset", lcd_rw, 0);
    rst = 1'b0;
  endtask

  task automatic t_full_sequence();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_and_check("full run");
  endtask

  task automatic t_done_idle();
    int en_seen = 0, done_lost = 0;
    for (int s = 0; s < 60; s++) begin
      @(negedge clk);
      if (lcd_en) en_seen++;
      if (!done) done_lost++;
    end
    chk(en_seen == 0, "R8", "idle enable after done", en_seen, 0);
    chk(done_lost == 0, "R8", "done held", done_lost, 0);
  endtask

  task automatic t_mid_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2 + PER + 1) @(negedge clk); // inside the second pulse
    chk(lcd_en == 1'b1 && lcd_db == 8'h0E, "R9", "second pulse active", lcd_db, 8'h0E);
    rst = 1'b1;
    @(negedge clk);
    chk(lcd_en == 1'b0, "R1", "enable dropped by reset", lcd_en, 0);
    chk(done == 1'b0, "R9", "done low after reset", done, 0);
    @(negedge clk);
    rst = 1'b0;
    run_and_check("R9 restart");
  endtask

  initial begin
    t_reset_state();
    t_full_sequence();
    t_done_idle();
    t_mid_reset();
    t_done_idle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule